// File: doc/BRIEF.md
# Prefix-Extended Immediate Subtract Unit

This block executes a 16-bit instruction that subtracts an immediate from one of sixteen 32-bit registers and writes the difference back to the same register. The instruction carries only a 6-bit immediate. Up to two extension-prefix instructions placed directly before it can widen that immediate to 19 or 32 bits. The unit accepts one instruction per cycle. Each instruction comes with a valid strobe and a flag that marks it as sitting in a branch delay slot. The unit keeps the register file and the condition flags, which are negative, zero, overflow and borrow, plus an interrupt-enable bit that a subtract never alters.

Prefixes build up in a small two-entry history, and any consumed instruction that is not a prefix clears that history. When the subtract sits in a delay slot, the pending prefixes are discarded and only the zero-extended 6-bit field is used. A registered read port exposes any register so that the contents can be observed.

Top module: `imm_sub_unit`

## Requirements
- R1: A subtract is encoded with instr[15:13]=011, instr[12:10]=001, instr[9:4]=imm6 and instr[3:0]=rd. With no pending prefix, it writes rd - zext(imm6) into rd. The write is visible one cycle after issue.
- R2: A prefix is encoded with instr[15:13]=110 and a 13-bit value in instr[12:0]. With one pending prefix, the subtrahend is the 19-bit value {prefix, imm6}, zero-extended to 32 bits.
- R3: With two pending prefixes, the subtrahend is {older prefix, newer prefix, imm6}. For example, two prefixes of 0x1fff followed by imm6=0x3f subtract 0xffffffff.
- R4: A third consecutive prefix evicts the oldest one, so only the two most recent prefixes take effect.
- R5: A subtract issued with in_delay_slot high ignores pending prefixes and uses zext(imm6). It also clears the pending prefixes.
- R6: Any valid instruction that is neither a subtract nor a prefix leaves the registers and flags unchanged and clears pending prefixes.
- R7: flag_c is set after a subtract exactly when rd < subtrahend as unsigned values.
- R8: flag_v is set after a subtract exactly when the operands differ in sign and the result's sign differs from rd's.
- R9: After a subtract, flag_n equals result bit 31 and flag_z is set exactly when the result is zero.
- R10: flag_ie keeps its reset value IE_INIT. The N, Z, V and C flags change only on a subtract.
- R11: Cycles with instr_valid low change nothing, and pending prefixes survive them.
- R12: Reset clears every register to zero and N, Z, V and C to 0, and sets flag_ie to IE_INIT.
- R13: rd_data shows the register selected by rd_addr with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| in_delay_slot | input | 1 | Instruction sits in a branch delay slot |
| rd_addr | input | 4 | Register read-port address |
| rd_data | output | 32 | Registered read-port data |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Borrow flag |
| flag_ie | output | 1 | Interrupt-enable flag (held) |

## Verification
The bench builds the unit with REG_CNT=16, which covers the full 4-bit register field, and with IE_INIT=1. A retained interrupt-enable value of one can be told apart from an accidental clear. Registers are loaded with arbitrary values through two-prefix subtracts. This brings the borrow and signed-overflow boundaries, a zero result, prefix eviction and delay-slot discard within reach. All of these are reached through the instruction port alone.

// File: rtl/isub_pkg.sv
package isub_pkg;
  localparam int INSTR_W = 16;
  localparam int DATA_W  = 32;
  localparam int PFX_W   = 13;
  localparam int IMM_W   = 6;
  localparam int RD_W    = 4;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_SUB  = 2'd1,
    OP_EXT  = 2'd2
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [IMM_W-1:0] imm6;
    logic [RD_W-1:0]  rd;
    logic [PFX_W-1:0] pfx;
  } dec_t;
endpackage

// File: rtl/isub_decode.sv
module isub_decode
  import isub_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output dec_t               dec
);
  always_comb begin
    dec.imm6 = instr[9:4];
    dec.rd   = instr[3:0];
    dec.pfx  = instr[PFX_W-1:0];
    if (instr[15:13] == 3'b011 && instr[12:10] == 3'b001)
      dec.op = OP_SUB;
    else if (instr[15:13] == 3'b110)
      dec.op = OP_EXT;
    else
      dec.op = OP_NONE;
  end
endmodule

// File: rtl/isub_prefix.sv
module isub_prefix
  import isub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  dec_t              dec,
  input  logic              in_delay_slot,
  output logic [DATA_W-1:0] operand
);
  logic [1:0]       depth;
  logic [PFX_W-1:0] older;
  logic [PFX_W-1:0] newer;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth <= 2'd0;
      older <= '0;
      newer <= '0;
    end else if (valid) begin
      if (dec.op == OP_EXT) begin
        older <= newer;
        newer <= dec.pfx;
        depth <= (depth == 2'd2) ? 2'd2 : depth + 2'd1;
      end else begin
        depth <= 2'd0;
      end
    end
  end

  always_comb begin
    if (in_delay_slot || depth == 2'd0)
      operand = {{(DATA_W-IMM_W){1'b0}}, dec.imm6};
    else if (depth == 2'd1)
      operand = {{(DATA_W-PFX_W-IMM_W){1'b0}}, newer, dec.imm6};
    else
      operand = {older, newer, dec.imm6};
  end

  // R4
  pfx_depth_chk: assert property (@(posedge clk) disable iff (rst) depth <= 2'd2);
  // R6
  pfx_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && dec.op != OP_EXT) |=> depth == 2'd0);
  // R11
  pfx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid |=> ($stable(depth) && $stable(newer) && $stable(older)));
endmodule

// File: rtl/isub_regfile.sv
module isub_regfile #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] xaddr,
  output logic [WIDTH-1:0]  xdata,
  input  logic [ADDR_W-1:0] paddr,
  output logic [WIDTH-1:0]  pdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pdata <= '0;
    else     pdata <= mem[paddr];
  end

  assign xdata = mem[xaddr];
endmodule

// File: rtl/isub_alu.sv
module isub_alu
  import isub_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] res,
  output logic              n,
  output logic              z,
  output logic              v,
  output logic              c
);
  logic [DATA_W:0] wide;

  always_comb begin
    wide = {1'b0, a} - {1'b0, b};
    res  = wide[DATA_W-1:0];
    c    = wide[DATA_W];
    n    = res[DATA_W-1];
    z    = (res == '0);
    v    = (a[DATA_W-1] ^ b[DATA_W-1]) & (res[DATA_W-1] ^ a[DATA_W-1]);
  end
endmodule

// File: rtl/imm_sub_unit.sv
module imm_sub_unit
  import isub_pkg::*;
#(
  parameter int   REG_CNT = 16,
  parameter logic IE_INIT = 1'b1,
  parameter int   ADDR_W  = $clog2(REG_CNT)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               in_delay_slot,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               flag_n,
  output logic               flag_z,
  output logic               flag_v,
  output logic               flag_c,
  output logic               flag_ie
);
  dec_t              dec;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] src;
  logic [DATA_W-1:0] diff;
  logic              n_nxt, z_nxt, v_nxt, c_nxt;
  logic              exec;

  assign exec = instr_valid && (dec.op == OP_SUB);

  isub_decode u_dec (.instr(instr), .dec(dec));

  isub_prefix u_pfx (
    .clk(clk), .rst(rst), .valid(instr_valid), .dec(dec),
    .in_delay_slot(in_delay_slot), .operand(operand)
  );

  isub_regfile #(.DEPTH(REG_CNT), .WIDTH(DATA_W), .ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .rst(rst), .we(exec), .waddr(dec.rd[ADDR_W-1:0]), .wdata(diff),
    .xaddr(dec.rd[ADDR_W-1:0]), .xdata(src), .paddr(rd_addr), .pdata(rd_data)
  );

  isub_alu u_alu (
    .a(src), .b(operand), .res(diff),
    .n(n_nxt), .z(z_nxt), .v(v_nxt), .c(c_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_n  <= 1'b0;
      flag_z  <= 1'b0;
      flag_v  <= 1'b0;
      flag_c  <= 1'b0;
      flag_ie <= IE_INIT;
    end else if (exec) begin
      flag_n <= n_nxt;
      flag_z <= z_nxt;
      flag_v <= v_nxt;
      flag_c <= c_nxt;
    end
  end

  // R5
  ds_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (exec && in_delay_slot) |-> operand[DATA_W-1:IMM_W] == '0);
  // R10
  ie_hold_chk: assert property (@(posedge clk) disable iff (rst) ##1 $stable(flag_ie));
  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exec |=> $stable({flag_n, flag_z, flag_v, flag_c}));
endmodule

// File: tb/imm_sub_unit_bench.sv
module imm_sub_unit_bench;
  localparam int  REG_CNT = 16;
  localparam logic IE_INIT = 1'b1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        in_delay_slot = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        flag_n, flag_z, flag_v, flag_c, flag_ie;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mreg [16];
  logic mn = 0, mz = 0, mv = 0, mc = 0;

  always #4 clk = ~clk;

  imm_sub_unit #(.REG_CNT(REG_CNT), .IE_INIT(IE_INIT)) u_imm_sub_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
    .in_delay_slot(in_delay_slot), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .flag_ie(flag_ie)
  );

  function automatic logic [15:0] enc_sub(input logic [3:0] rd, input logic [5:0] imm);
    return {3'b011, 3'b001, imm, rd};
  endfunction
  function automatic logic [15:0] enc_ext(input logic [12:0] v);
    return {3'b110, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w, input logic ds);
    @(negedge clk);
    instr_valid = 1'b1; instr = w; in_delay_slot = ds;
  endtask

  task automatic idle();
    @(negedge clk);
    instr_valid = 1'b0; instr = '0; in_delay_slot = 1'b0;
  endtask

  // model of a subtract with a given effective subtrahend
  task automatic model_sub(input int r, input logic [31:0] b);
    logic [32:0] w;
    w = {1'b0, mreg[r]} - {1'b0, b};
    mv = (mreg[r][31] ^ b[31]) & (w[31] ^ mreg[r][31]);
    mreg[r] = w[31:0];
    mc = w[32]; mn = w[31]; mz = (w[31:0] == 0);
  endtask

  task automatic check_reg(input string req, input int r);
    idle();
    rd_addr = r[3:0];
    @(negedge clk);
    chk(req, rd_data, mreg[r]);
  endtask

  task automatic check_flags(input string req);
    idle();
    chk(req, {27'b0, flag_ie, flag_n, flag_z, flag_v, flag_c},
        {27'b0, IE_INIT, mn, mz, mv, mc});
  endtask

  task automatic sub32(input int r, input logic [31:0] b);
    issue(enc_ext(b[31:19]), 1'b0);
    issue(enc_ext(b[18:6]), 1'b0);
    issue(enc_sub(r[3:0], b[5:0]), 1'b0);
    model_sub(r, b);
  endtask

  task automatic load(input int r, input logic [31:0] v);
    sub32(r, mreg[r] - v);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 16; i++) check_reg("R12 reg", i);
    check_flags("R12 flags");
  endtask

  task automatic t_plain();
    issue(enc_sub(4'd0, 6'h3f), 1'b0);
    model_sub(0, 32'h3f);
    check_reg("R1 plain", 0);
    check_flags("R1 flags");
  endtask

  task automatic t_one_pfx();
    load(2, 32'h0010_0000);
    issue(enc_ext(13'h1234), 1'b0);
    issue(enc_sub(4'd2, 6'h15), 1'b0);
    model_sub(2, {13'h0, 13'h1234, 6'h15});
    check_reg("R2 one prefix", 2);
  endtask

  task automatic t_two_pfx();
    load(1, 32'h0000_1000);
    issue(enc_ext(13'h1fff), 1'b0);
    issue(enc_ext(13'h1fff), 1'b0);
    issue(enc_sub(4'd1, 6'h3f), 1'b0);
    model_sub(1, 32'hffff_ffff);
    chk("R3 all-ones subtrahend", mreg[1], 32'h0000_1001);
    check_reg("R3 two prefixes", 1);
  endtask

  task automatic t_evict();
    load(6, 32'h0);
    issue(enc_ext(13'h0aaa), 1'b0);
    issue(enc_ext(13'h0123), 1'b0);
    issue(enc_ext(13'h1456), 1'b0);
    issue(enc_sub(4'd6, 6'h2a), 1'b0);
    model_sub(6, {13'h0123, 13'h1456, 6'h2a});
    check_reg("R4 eviction", 6);
  endtask

  task automatic t_delay();
    load(7, 32'h1000_0000);
    issue(enc_ext(13'h1111), 1'b0);
    issue(enc_ext(13'h0222), 1'b0);
    issue(enc_sub(4'd7, 6'h05), 1'b1);
    model_sub(7, 32'h5);
    check_reg("R5 delay slot imm6 only", 7);
    issue(enc_sub(4'd7, 6'h09), 1'b0);
    model_sub(7, 32'h9);
    check_reg("R5 prefixes cleared", 7);
  endtask

  task automatic t_nop();
    load(8, 32'h55);
    issue(enc_ext(13'h0fff), 1'b0);
    issue(16'h0000, 1'b0);
    issue({3'b011, 3'b000, 6'h3f, 4'd8}, 1'b0);
    check_reg("R6 no-op keeps reg", 8);
    check_flags("R6 no-op keeps flags");
    issue(enc_sub(4'd8, 6'h01), 1'b0);
    model_sub(8, 32'h1);
    check_reg("R6 prefix cleared", 8);
  endtask

  task automatic t_gap();
    load(9, 32'h0200_0000);
    issue(enc_ext(13'h0010), 1'b0);
    idle(); idle(); idle();
    issue(enc_sub(4'd9, 6'h01), 1'b0);
    model_sub(9, {13'h0, 13'h0010, 6'h01});
    check_reg("R11 prefix survives idle", 9);
  endtask

  task automatic t_flags();
    load(3, 32'h8000_0000);
    issue(enc_sub(4'd3, 6'h01), 1'b0);
    model_sub(3, 32'h1);
    check_flags("R8 overflow");
    chk("R8 v set", {31'b0, flag_v}, 32'h1);
    load(4, 32'h5);
    issue(enc_sub(4'd4, 6'h05), 1'b0);
    model_sub(4, 32'h5);
    check_flags("R9 zero");
    chk("R9 z set", {31'b0, flag_z}, 32'h1);
    load(5, 32'h3);
    issue(enc_sub(4'd5, 6'h04), 1'b0);
    model_sub(5, 32'h4);
    check_flags("R7 borrow");
    chk("R7 c set", {31'b0, flag_c}, 32'h1);
    chk("R9 n set", {31'b0, flag_n}, 32'h1);
    check_reg("R7 result", 5);
  endtask

  task automatic t_latency();
    idle();
    rd_addr = 4'd3;
    @(negedge clk);
    rd_addr = 4'd4;
    #1;
    chk("R13 old address held", rd_data, mreg[3]);
    @(negedge clk);
    chk("R13 new address after edge", rd_data, mreg[4]);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mreg[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_one_pfx();
    t_two_pfx();
    t_evict();
    t_delay();
    t_nop();
    t_gap();
    t_flags();
    t_latency();
    check_flags("R10 ie held");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule